// File: doc/BRIEF.md
# I3C Target Private-Write Receiver

This block is the data path of an I3C target once a private-write header has been decoded on the bus. A bus-level front end hands it one strobe per header (with the two-bit direction code), one strobe per 9-bit data word, and one strobe when the transfer ends with a Stop or a Repeated Start. The receiver checks the parity bit of each word and keeps a count of the words received in the current transfer. Bytes that are good and within the length limit go into a small receive FIFO, which software drains one byte per read.

The block raises four sticky event flags: receive parity error, overrun, length overflow and transfer complete. Software clears them one bit at a time with write-1-to-clear. The block holds the 16-bit maximum write length register. A bus command can load it and software can load it; when both write in the same cycle, the software value is kept. The value is always readable, so the front end can answer a get-length command from it. An acknowledge setting with a one-shot option decides whether a write header is acknowledged.

The control is a four-state machine. `ST_IDLE` is the state between transfers. `ST_RECV` receives the words of an acknowledged write. `ST_DROP` discards everything after a length overflow. `ST_SKIP` ignores a transfer that was not acknowledged or is not a write. The transitions are:
- hdr_accept: any state goes to `ST_RECV` on an acknowledged write header.
- hdr_reject: any state goes to `ST_SKIP` on any other header.
- limit_hit: `ST_RECV` goes to `ST_DROP` on a word that arrives when the count is already at a nonzero limit.
- end_xfer: `ST_RECV`, `ST_DROP` or `ST_SKIP` goes to `ST_IDLE` on Stop or Repeated Start.

A header takes priority over an end strobe in the same cycle.

Top module: `pw_rx_target`

## Requirements
- R1: A word is `word_i[8:1]` = data and `word_i[0]` = T-bit. The T-bit gives odd parity, so the total number of ones in all 9 bits must be odd. A word that fails this check in `ST_RECV` sets flag bit 0 (parity error) one cycle later, and its byte is not stored.
- R2: Good bytes are stored in arrival order. `rd_data_o` shows the oldest byte and `rx_avail_o` is high whenever the FIFO holds a byte. A `rd_i` pulse removes exactly one byte, and `rx_avail_o` only falls after a read.
- R3: A good word that arrives while the FIFO holds `FIFO_DEPTH` bytes sets flag bit 1 (overrun). The byte is lost and the stored bytes are unchanged.
- R4: `stop_i` in `ST_RECV` or `ST_DROP` sets flag bit 3 (complete) on the next cycle. `stop_i` in `ST_IDLE` or `ST_SKIP` does not set it.
- R5: Every `hdr_stb_i` loads `hdr_dir_i` into `dir_o`. `dir_o` holds its value through the end of the transfer. `dir_clr_i` sets it to 0, but a header in the same cycle wins over the clear.
- R6: The maximum write length is 16 bits wide, and 0 means no limit. With 0, any number of words is taken without setting flag bit 2.
- R7: With a nonzero limit L, the first L words of a transfer are handled as usual; words with bad parity count toward L. Word L+1 sets flag bits 2 (length overflow) and 1 (overrun). That word and every later word up to the end strobe are discarded, even when the FIFO has room.
- R8: The word count returns to zero at each header, and the discard state ends at Stop or Repeated Start. The next acknowledged write stores bytes again.
- R9: `sw_mwl_we_i` loads `sw_mwl_i` and `ccc_mwl_we_i` loads `ccc_mwl_i`. When both are high in the same cycle, the software value is kept. `mwl_o` shows the register; its value after reset is `MWL_RESET`.
- R10: `hdr_ack_o` is high during a header with direction `2'b10` (write) when `nack_cfg_o` is 0. When it is low, the words and end strobe of that transfer change no flag and store nothing.
- R11: With `oneshot_o` set, the first acknowledged write header sets `nack_cfg_o` to 1 and clears `oneshot_o`. A software load through `sw_ack_we_i` in the same cycle wins.
- R12: All four flags (bit 0 parity error, 1 overrun, 2 length overflow, 3 complete) are sticky. A 1 in `flag_clr_i` clears the matching bit, and a set event in the same cycle leaves the bit set.
- R13: A header whose direction is not `2'b10` still loads `dir_o`, but the words that follow are neither stored nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_stb_i | input | 1 | Address header matched this target |
| hdr_dir_i | input | 2 | Direction code of the header (2'b10 = write) |
| hdr_ack_o | output | 1 | Header is acknowledged (combinational) |
| word_valid_i | input | 1 | One received data word |
| word_i | input | 9 | Data in [8:1], T-bit in [0] |
| stop_i | input | 1 | Stop or Repeated Start |
| rd_i | input | 1 | Software read of the receive buffer |
| rd_data_o | output | 8 | Oldest stored byte |
| rx_avail_o | output | 1 | Receive buffer holds a byte |
| flags_o | output | 4 | Sticky flags: parity, overrun, length overflow, complete |
| flag_clr_i | input | 4 | Write-1-to-clear for flags_o |
| dir_o | output | 2 | Captured direction code |
| dir_clr_i | input | 1 | Clears dir_o |
| sw_mwl_we_i | input | 1 | Software write of the length register |
| sw_mwl_i | input | 16 | Software length value |
| ccc_mwl_we_i | input | 1 | Bus-command write of the length register |
| ccc_mwl_i | input | 16 | Bus-command length value |
| mwl_o | output | 16 | Maximum write length, 0 = unlimited |
| sw_ack_we_i | input | 1 | Software write of the acknowledge setting |
| sw_nack_i | input | 1 | New NACK bit (0 = acknowledge) |
| sw_oneshot_i | input | 1 | New one-shot enable |
| nack_cfg_o | output | 1 | Current NACK bit |
| oneshot_o | output | 1 | Current one-shot enable |

## Verification
Several rules are checked on every cycle:
- a flag rises only with its cause: complete after an end strobe, parity error after a word, length overflow together with overrun;
- flags stay set until cleared;
- the length register takes the software value over the bus-command value;
- `dir_o` follows each header;
- the receive buffer empties only through a read.

Other behaviour depends on counting and data contents, so only the directed scenarios can show it:
- the exact word where the limit is crossed;
- bad-parity words counting toward the limit;
- discarding while the FIFO still has room;
- the order of the bytes read back;
- the one-shot acknowledge reverting;
- nothing being stored from a rejected or read-direction transfer.

// File: rtl/pw_rx_pkg.sv
`timescale 1ns/1ps
package pw_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_DROP = 2'd2,
        ST_SKIP = 2'd3
    } pw_state_e;

    localparam logic [1:0] DIR_WRITE = 2'b10;

    localparam int FLG_PERR  = 0;
    localparam int FLG_OVR   = 1;
    localparam int FLG_MWLO  = 2;
    localparam int FLG_TCOMP = 3;
    localparam int NUM_FLAGS = 4;

endpackage

// File: rtl/pw_rx_fifo.sv
`timescale 1ns/1ps
module pw_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr_q, rptr_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr_q] <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) begin
                wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
            end
            if (do_pop) begin
                rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rdata_o = mem[rptr_q];
    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == FULLC);

endmodule

// File: rtl/pw_rx_cfg.sv
`timescale 1ns/1ps
module pw_rx_cfg #(
    parameter int          LEN_W     = 16,
    parameter logic [15:0] MWL_RESET = 16'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_mwl_we_i,
    input  logic [LEN_W-1:0] sw_mwl_i,
    input  logic             ccc_mwl_we_i,
    input  logic [LEN_W-1:0] ccc_mwl_i,
    output logic [LEN_W-1:0] mwl_o,
    input  logic             sw_ack_we_i,
    input  logic             sw_nack_i,
    input  logic             sw_oneshot_i,
    input  logic             hdr_acked_i,
    output logic             nack_o,
    output logic             oneshot_o
);
    logic [LEN_W-1:0] mwl_q;
    logic             nack_q, oneshot_q;

    // Length register: software has precedence over the bus command.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mwl_q <= LEN_W'(MWL_RESET);
        end else if (sw_mwl_we_i) begin
            mwl_q <= sw_mwl_i;
        end else if (ccc_mwl_we_i) begin
            mwl_q <= ccc_mwl_i;
        end
    end

    // Acknowledge setting with single-transfer option.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nack_q    <= 1'b0;
            oneshot_q <= 1'b0;
        end else if (sw_ack_we_i) begin
            nack_q    <= sw_nack_i;
            oneshot_q <= sw_oneshot_i;
        end else if (hdr_acked_i && oneshot_q) begin
            nack_q    <= 1'b1;
            oneshot_q <= 1'b0;
        end
    end

    assign mwl_o     = mwl_q;
    assign nack_o    = nack_q;
    assign oneshot_o = oneshot_q;

endmodule

// File: rtl/pw_rx_ctrl.sv
`timescale 1ns/1ps
module pw_rx_ctrl
    import pw_rx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hdr_stb_i,
    input  logic [1:0]           hdr_dir_i,
    input  logic                 nack_i,
    output logic                 hdr_ack_o,
    input  logic                 word_valid_i,
    input  logic [8:0]           word_i,
    input  logic                 stop_i,
    input  logic [LEN_W-1:0]     mwl_i,
    input  logic                 fifo_full_i,
    output logic                 push_o,
    output logic [7:0]           push_data_o,
    input  logic [NUM_FLAGS-1:0] flag_clr_i,
    output logic [NUM_FLAGS-1:0] flags_o,
    input  logic                 dir_clr_i,
    output logic [1:0]           dir_o
);
    localparam logic [LEN_W-1:0] CNT_MAX = '1;

    pw_state_e             state_q, state_d;
    logic [LEN_W-1:0]      cnt_q;
    logic [1:0]            dir_q;
    logic [NUM_FLAGS-1:0]  flag_set;
    logic [NUM_FLAGS-1:0]  flags_q;
    logic                  parity_ok, at_limit, count_word;

    assign parity_ok = ^word_i;
    assign at_limit  = (mwl_i != '0) && (cnt_q >= mwl_i);
    assign hdr_ack_o = hdr_stb_i && (hdr_dir_i == DIR_WRITE) && !nack_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a header always restarts, then per-state transitions
    always_comb begin
        state_d = state_q;
        if (hdr_stb_i) begin
            state_d = hdr_ack_o ? ST_RECV : ST_SKIP;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RECV: begin
                    if (stop_i) begin
                        state_d = ST_IDLE;
                    end else if (word_valid_i && at_limit) begin
                        state_d = ST_DROP;
                    end
                end
                ST_DROP: if (stop_i) state_d = ST_IDLE;
                ST_SKIP: if (stop_i) state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs: per-word action and flag set events
    always_comb begin
        push_o     = 1'b0;
        flag_set   = '0;
        count_word = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_SKIP: begin
                push_o = 1'b0;
            end
            ST_RECV: begin
                if (word_valid_i) begin
                    if (at_limit) begin
                        flag_set[FLG_MWLO] = 1'b1;
                        flag_set[FLG_OVR]  = 1'b1;
                    end else begin
                        count_word = 1'b1;
                        if (!parity_ok) begin
                            flag_set[FLG_PERR] = 1'b1;
                        end else if (fifo_full_i) begin
                            flag_set[FLG_OVR] = 1'b1;
                        end else begin
                            push_o = 1'b1;
                        end
                    end
                end
                if (stop_i) begin
                    flag_set[FLG_TCOMP] = 1'b1;
                end
            end
            ST_DROP: begin
                if (word_valid_i) begin
                    flag_set[FLG_MWLO] = 1'b1;
                    flag_set[FLG_OVR]  = 1'b1;
                end
                if (stop_i) begin
                    flag_set[FLG_TCOMP] = 1'b1;
                end
            end
        endcase
    end

    assign push_data_o = word_i[8:1];

    // Word counter of the current transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hdr_stb_i) begin
            cnt_q <= '0;
        end else if (count_word && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Direction status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (hdr_stb_i) begin
            dir_q <= hdr_dir_i;
        end else if (dir_clr_i) begin
            dir_q <= '0;
        end
    end
    assign dir_o = dir_q;

    // Sticky flags, set beats clear
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_q[g] <= 1'b0;
            end else if (flag_set[g]) begin
                flags_q[g] <= 1'b1;
            end else if (flag_clr_i[g]) begin
                flags_q[g] <= 1'b0;
            end
        end
    end
    assign flags_o = flags_q;

endmodule

// File: rtl/pw_rx_target.sv
`timescale 1ns/1ps
module pw_rx_target
    import pw_rx_pkg::*;
#(
    parameter int          FIFO_DEPTH = 4,
    parameter int          LEN_W      = 16,
    parameter logic [15:0] MWL_RESET  = 16'd0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hdr_stb_i,
    input  logic [1:0]           hdr_dir_i,
    output logic                 hdr_ack_o,
    input  logic                 word_valid_i,
    input  logic [8:0]           word_i,
    input  logic                 stop_i,
    input  logic                 rd_i,
    output logic [7:0]           rd_data_o,
    output logic                 rx_avail_o,
    output logic [NUM_FLAGS-1:0] flags_o,
    input  logic [NUM_FLAGS-1:0] flag_clr_i,
    output logic [1:0]           dir_o,
    input  logic                 dir_clr_i,
    input  logic                 sw_mwl_we_i,
    input  logic [LEN_W-1:0]     sw_mwl_i,
    input  logic                 ccc_mwl_we_i,
    input  logic [LEN_W-1:0]     ccc_mwl_i,
    output logic [LEN_W-1:0]     mwl_o,
    input  logic                 sw_ack_we_i,
    input  logic                 sw_nack_i,
    input  logic                 sw_oneshot_i,
    output logic                 nack_cfg_o,
    output logic                 oneshot_o
);
    logic       nack_w, push_w, full_w, empty_w;
    logic [7:0] push_data_w;

    pw_rx_cfg #(
        .LEN_W     (LEN_W),
        .MWL_RESET (MWL_RESET)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_mwl_we_i  (sw_mwl_we_i),
        .sw_mwl_i     (sw_mwl_i),
        .ccc_mwl_we_i (ccc_mwl_we_i),
        .ccc_mwl_i    (ccc_mwl_i),
        .mwl_o        (mwl_o),
        .sw_ack_we_i  (sw_ack_we_i),
        .sw_nack_i    (sw_nack_i),
        .sw_oneshot_i (sw_oneshot_i),
        .hdr_acked_i  (hdr_ack_o),
        .nack_o       (nack_w),
        .oneshot_o    (oneshot_o)
    );

    pw_rx_ctrl #(
        .LEN_W (LEN_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .hdr_stb_i    (hdr_stb_i),
        .hdr_dir_i    (hdr_dir_i),
        .nack_i       (nack_w),
        .hdr_ack_o    (hdr_ack_o),
        .word_valid_i (word_valid_i),
        .word_i       (word_i),
        .stop_i       (stop_i),
        .mwl_i        (mwl_o),
        .fifo_full_i  (full_w),
        .push_o       (push_w),
        .push_data_o  (push_data_w),
        .flag_clr_i   (flag_clr_i),
        .flags_o      (flags_o),
        .dir_clr_i    (dir_clr_i),
        .dir_o        (dir_o)
    );

    pw_rx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (8)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_w),
        .wdata_i (push_data_w),
        .pop_i   (rd_i),
        .rdata_o (rd_data_o),
        .empty_o (empty_w),
        .full_o  (full_w)
    );

    assign rx_avail_o = !empty_w;
    assign nack_cfg_o = nack_w;

endmodule

// File: rtl/pw_rx_checker.sv
`timescale 1ns/1ps
module pw_rx_checker #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hdr_stb_i,
    input logic [1:0]       hdr_dir_i,
    input logic             word_valid_i,
    input logic             stop_i,
    input logic             rd_i,
    input logic             rx_avail_o,
    input logic [3:0]       flags_o,
    input logic [3:0]       flag_clr_i,
    input logic [1:0]       dir_o,
    input logic             sw_mwl_we_i,
    input logic [LEN_W-1:0] sw_mwl_i,
    input logic             ccc_mwl_we_i,
    input logic [LEN_W-1:0] ccc_mwl_i,
    input logic [LEN_W-1:0] mwl_o
);
    assert_perr_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[0]) |-> $past(word_valid_i));

    assert_empty_only_by_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_avail_o) |-> $past(rd_i));

    assert_tcomp_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[3]) |-> $past(stop_i));

    assert_dir_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_stb_i |=> (dir_o == $past(hdr_dir_i)));

    assert_overflow_with_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[2]) |-> flags_o[1]);

    assert_sw_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_mwl_we_i |=> (mwl_o == $past(sw_mwl_i)));

    assert_ccc_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ccc_mwl_we_i && !sw_mwl_we_i) |=> (mwl_o == $past(ccc_mwl_i)));

    for (genvar i = 0; i < 4; i++) begin : g_sticky
        assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[i] && !flag_clr_i[i]) |=> flags_o[i]);
    end

endmodule

bind pw_rx_target pw_rx_checker #(.LEN_W(LEN_W)) u_pw_rx_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .hdr_stb_i    (hdr_stb_i),
    .hdr_dir_i    (hdr_dir_i),
    .word_valid_i (word_valid_i),
    .stop_i       (stop_i),
    .rd_i         (rd_i),
    .rx_avail_o   (rx_avail_o),
    .flags_o      (flags_o),
    .flag_clr_i   (flag_clr_i),
    .dir_o        (dir_o),
    .sw_mwl_we_i  (sw_mwl_we_i),
    .sw_mwl_i     (sw_mwl_i),
    .ccc_mwl_we_i (ccc_mwl_we_i),
    .ccc_mwl_i    (ccc_mwl_i),
    .mwl_o        (mwl_o)
);

// File: tb/tb_pw_rx_target.sv
`timescale 1ns/1ps
module tb_pw_rx_target;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_stb_i = 1'b0;
    logic [1:0]  hdr_dir_i = 2'b00;
    logic        hdr_ack_o;
    logic        word_valid_i = 1'b0;
    logic [8:0]  word_i = '0;
    logic        stop_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [7:0]  rd_data_o;
    logic        rx_avail_o;
    logic [3:0]  flags_o;
    logic [3:0]  flag_clr_i = '0;
    logic [1:0]  dir_o;
    logic        dir_clr_i = 1'b0;
    logic        sw_mwl_we_i = 1'b0;
    logic [15:0] sw_mwl_i = '0;
    logic        ccc_mwl_we_i = 1'b0;
    logic [15:0] ccc_mwl_i = '0;
    logic [15:0] mwl_o;
    logic        sw_ack_we_i = 1'b0;
    logic        sw_nack_i = 1'b0;
    logic        sw_oneshot_i = 1'b0;
    logic        nack_cfg_o;
    logic        oneshot_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic last_ack;

    always #10 clk = ~clk;

    pw_rx_target dut (.*);

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(logic [7:0] d, bit good);
        word_valid_i = 1'b1;
        word_i = {d, good ? ~(^d) : (^d)};
        tick();
        word_valid_i = 1'b0;
    endtask

    task automatic header(logic [1:0] dir);
        hdr_stb_i = 1'b1;
        hdr_dir_i = dir;
        #1 last_ack = hdr_ack_o;
        tick();
        hdr_stb_i = 1'b0;
    endtask

    task automatic end_xfer();
        stop_i = 1'b1;
        tick();
        stop_i = 1'b0;
    endtask

    task automatic pop(logic [7:0] exp, string req);
        chk(req, rx_avail_o, 1);
        chk(req, rd_data_o, exp);
        rd_i = 1'b1;
        tick();
        rd_i = 1'b0;
    endtask

    task automatic clear_all();
        flag_clr_i = 4'hF;
        dir_clr_i = 1'b1;
        tick();
        flag_clr_i = '0;
        dir_clr_i = 1'b0;
    endtask

    task automatic set_mwl(logic [15:0] v);
        sw_mwl_we_i = 1'b1;
        sw_mwl_i = v;
        tick();
        sw_mwl_we_i = 1'b0;
    endtask

    task automatic set_ack(bit nack, bit oneshot);
        sw_ack_we_i = 1'b1;
        sw_nack_i = nack;
        sw_oneshot_i = oneshot;
        tick();
        sw_ack_we_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 reset flags", flags_o, 0);
        chk("R5 reset dir", dir_o, 0);
        chk("R2 reset avail", rx_avail_o, 0);
        chk("R9 reset mwl", mwl_o, 0);
        chk("R11 reset nack", nack_cfg_o, 0);
    endtask

    task automatic t_basic();
        header(2'b10);
        chk("R10 write header acked", last_ack, 1);
        send(8'hA5, 1);
        send(8'h3C, 1);
        send(8'h0F, 1);
        pop(8'hA5, "R2 order 0");
        pop(8'h3C, "R2 order 1");
        pop(8'h0F, "R2 order 2");
        chk("R2 empty after reads", rx_avail_o, 0);
        chk("R1 no error on good words", flags_o, 0);
        end_xfer();
        chk("R4 complete after stop", flags_o, 4'b1000);
        chk("R5 dir holds after stop", dir_o, 2'b10);
        clear_all();
    endtask

    task automatic t_parity();
        header(2'b10);
        send(8'h11, 1);
        send(8'h22, 0);
        chk("R1 parity error flag", flags_o[0], 1);
        send(8'h33, 1);
        pop(8'h11, "R1 good byte kept");
        pop(8'h33, "R1 bad byte skipped");
        chk("R1 nothing more stored", rx_avail_o, 0);
        end_xfer();
        clear_all();
    endtask

    task automatic t_full();
        header(2'b10);
        for (int i = 1; i <= 4; i++) send(8'(i), 1);
        chk("R3 no overrun at depth", flags_o[1], 0);
        send(8'h55, 1);
        chk("R3 overrun when full", flags_o[1], 1);
        chk("R3 not a length overflow", flags_o[2], 0);
        for (int i = 1; i <= 4; i++) pop(8'(i), "R3 contents kept");
        chk("R3 lost byte absent", rx_avail_o, 0);
        end_xfer();
        clear_all();
    endtask

    task automatic t_limit();
        set_mwl(16'd3);
        header(2'b10);
        send(8'h81, 1);
        send(8'h82, 0);
        send(8'h83, 1);
        chk("R7 no overflow at limit", flags_o[2], 0);
        send(8'h84, 1);
        chk("R7 length overflow", flags_o[2], 1);
        chk("R7 overrun with overflow", flags_o[1], 1);
        send(8'h85, 1);
        pop(8'h81, "R7 first kept");
        pop(8'h83, "R7 third kept");
        chk("R7 later words dropped despite room", rx_avail_o, 0);
        end_xfer();
        chk("R4 complete after drop", flags_o[3], 1);
        clear_all();
        header(2'b10);
        send(8'h91, 1);
        send(8'h92, 1);
        pop(8'h91, "R8 new transfer stores");
        pop(8'h92, "R8 count restarted");
        chk("R8 no overflow after restart", flags_o[2], 0);
        end_xfer();
        clear_all();
        set_mwl(16'd0);
    endtask

    task automatic t_unlimited();
        header(2'b10);
        for (int i = 0; i < 10; i++) begin
            send(8'(8'h40 + i), 1);
            pop(8'(8'h40 + i), "R6 unlimited data");
        end
        chk("R6 no length overflow with zero", flags_o[2], 0);
        chk("R6 no overrun with zero", flags_o[1], 0);
        end_xfer();
        clear_all();
    endtask

    task automatic t_mwl_prio();
        ccc_mwl_we_i = 1'b1;
        ccc_mwl_i = 16'd7;
        tick();
        ccc_mwl_we_i = 1'b0;
        chk("R9 bus command load", mwl_o, 7);
        ccc_mwl_we_i = 1'b1;
        ccc_mwl_i = 16'd5;
        sw_mwl_we_i = 1'b1;
        sw_mwl_i = 16'hBEEF;
        tick();
        ccc_mwl_we_i = 1'b0;
        sw_mwl_we_i = 1'b0;
        chk("R9 software wins", mwl_o, 16'hBEEF);
        set_mwl(16'd0);
        chk("R9 software load", mwl_o, 0);
    endtask

    task automatic t_nack();
        set_ack(1, 0);
        header(2'b10);
        chk("R10 header nacked", last_ack, 0);
        send(8'h66, 1);
        send(8'h67, 0);
        chk("R10 nothing stored", rx_avail_o, 0);
        end_xfer();
        chk("R10 no flags", flags_o, 0);
        set_ack(0, 0);
        clear_all();
    endtask

    task automatic t_oneshot();
        set_ack(0, 1);
        header(2'b10);
        chk("R11 first header acked", last_ack, 1);
        chk("R11 nack set after use", nack_cfg_o, 1);
        chk("R11 oneshot cleared", oneshot_o, 0);
        end_xfer();
        header(2'b10);
        chk("R11 second header nacked", last_ack, 0);
        end_xfer();
        set_ack(0, 0);
        clear_all();
    endtask

    task automatic t_dir();
        header(2'b01);
        chk("R13 read header not acked", last_ack, 0);
        chk("R5 dir captured", dir_o, 2'b01);
        send(8'h77, 1);
        chk("R13 read words not stored", rx_avail_o, 0);
        end_xfer();
        chk("R13 no complete on read", flags_o, 0);
        chk("R5 dir holds", dir_o, 2'b01);
        dir_clr_i = 1'b1;
        tick();
        dir_clr_i = 1'b0;
        chk("R5 dir cleared", dir_o, 0);
        dir_clr_i = 1'b1;
        header(2'b10);
        dir_clr_i = 1'b0;
        chk("R5 header beats clear", dir_o, 2'b10);
        end_xfer();
        clear_all();
    endtask

    task automatic t_flags();
        header(2'b10);
        send(8'h01, 0);
        send(8'h02, 1);
        flag_clr_i = 4'b0001;
        word_valid_i = 1'b1;
        word_i = {8'h03, 1'b0 ^ ~(^8'h03) ^ 1'b1};
        tick();
        word_valid_i = 1'b0;
        flag_clr_i = '0;
        chk("R12 set beats clear", flags_o[0], 1);
        flag_clr_i = 4'b0010;
        tick();
        flag_clr_i = '0;
        chk("R12 other bit untouched", flags_o[0], 1);
        flag_clr_i = 4'b0001;
        tick();
        flag_clr_i = '0;
        chk("R12 w1c clears", flags_o[0], 0);
        pop(8'h02, "R12 stored byte");
        end_xfer();
        clear_all();
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog R1: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_basic();
        t_parity();
        t_full();
        t_limit();
        t_unlimited();
        t_mwl_prio();
        t_nack();
        t_oneshot();
        t_dir();
        t_flags();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule